// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Assignable Prescaler

This block is the main event timer of a small microcontroller. Its 8-bit count register advances from one of two sources. In timer mode the source is the core's instruction-cycle tick, a one-clock strobe that fires once every one or two clock periods. In counter mode the source is a chosen edge of an external pin. Before edge detection the pin passes through a two-flop synchroniser. An optional power-of-two prescaler can slow the count. The prescaler can also be handed over to another consumer, and then every qualifying tick advances the count directly.

Software can load the count register over a bus at any time. A load restarts the prescaler from zero. The timer then stays frozen for the next two instruction cycles, so that the loaded value is seen unchanged before counting resumes. When the count wraps from FFh to 00h, a sticky overflow flag is set. The flag stays set until software clears it with a separate write strobe.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 00h and the overflow flag is 0.
- R2: With `srcSel`=0 and `preBypass`=1, the count rises by exactly one on the clock edge at which `cycTick` is high (when not frozen by R8).
- R3: With `preBypass`=0, qualifying ticks are divided by 2^(`preRatio`+1): `preRatio`=0 gives 2 and 7 gives 256. The division counts from zero after each bus write.
- R4: With `srcSel`=1 and `edgeSel`=0, each rising edge of `extPin` advances the count once. The new value appears at the third rising clock edge after the pin changes. Falling edges do nothing.
- R5: With `srcSel`=1 and `edgeSel`=1, only falling edges of `extPin` advance the count, with the same latency as R4.
- R6: In counter mode `cycTick` never advances the count, and in timer mode `extPin` activity never advances it.
- R7: When `busWrEn` is high at a clock edge, `count` equals `busWrData` after that edge.
- R8: After a bus write, the next two clock edges at which `cycTick` is high give no increment, and nor does any pin edge before them, in either mode.
- R9: An increment from FFh gives 00h and sets `ovfFlag`.
- R10: `ovfFlag` stays set until a clock edge with `flagClr` high. A wrap on that same edge leaves it set.
- R11: A bus write takes priority over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycTick | input | 1 | One-clock strobe per instruction cycle |
| extPin | input | 1 | External count pin, asynchronous |
| srcSel | input | 1 | 0 = instruction cycles, 1 = pin edges |
| edgeSel | input | 1 | 0 = rising pin edges, 1 = falling pin edges |
| preBypass | input | 1 | 1 = prescaler assigned elsewhere, not used here |
| preRatio | input | 3 | Prescale divide by 2^(value+1) |
| busWrEn | input | 1 | Bus write strobe for the count register |
| busWrData | input | 8 | Bus write data |
| flagClr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count register |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
A prescaler that has drifted or was not cleared on a write shows up as an increment one or more ticks early or late. The bench therefore compares the count on every clock against an independent model. A wrong hold counter makes the count move during the two frozen instruction cycles, which is visible within three ticks of any load. A wrong synchroniser depth or edge polarity shifts the count by a whole clock, or makes it change on the wrong pin transition, so a cycle-exact comparison catches it within three clocks of the edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef struct packed {
    logic load;
    logic incr;
  } tmr_strobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int RATIO_W     = $clog2(PRE_W),
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycTick,
  input  logic               extPin,
  input  logic               srcSel,
  input  logic               edgeSel,
  input  logic               preBypass,
  input  logic [RATIO_W-1:0] preRatio,
  input  logic               busWrEn,
  output tmr_strobe_t        strb
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [PRE_W-1:0]       preCnt;
  logic [PRE_W:0]         prePow;
  logic [PRE_W-1:0]       preMask;
  logic [HOLD_W-1:0]      holdCnt;
  logic                   pinNow, edgePulse, tickQual, tickOk, preMatch;

  // pin synchroniser chain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= extPin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= pinNow;
  end

  always_comb begin
    edgePulse = edgeSel ? (!pinNow && prevQ) : (pinNow && !prevQ);
    tickQual  = srcSel ? edgePulse : cycTick;
    tickOk    = tickQual && (holdCnt == '0);
    prePow    = (PRE_W+1)'(2) << preRatio;
    preMask   = prePow[PRE_W-1:0] - PRE_W'(1);
    preMatch  = ((preCnt & preMask) == preMask);
    strb.load = busWrEn;
    strb.incr = !busWrEn && tickOk && (preBypass || preMatch);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      holdCnt <= '0;
    end else if (busWrEn) begin
      preCnt  <= '0;
      holdCnt <= HOLD_W'(HOLD_TICKS);
    end else begin
      if (tickOk && !preBypass) preCnt <= preCnt + PRE_W'(1);
      if (cycTick && holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  logic [CNT_W-1:0] busWrData,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  logic wrapNow;

  assign wrapNow = strb.incr && (&count);

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (strb.load) count <= busWrData;
    else if (strb.incr) count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ovfFlag <= 1'b0;
    else if (wrapNow) ovfFlag <= 1'b1;
    else if (flagClr) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 8,
  parameter int RATIO_W = $clog2(PRE_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycTick,
  input  logic               extPin,
  input  logic               srcSel,
  input  logic               edgeSel,
  input  logic               preBypass,
  input  logic [RATIO_W-1:0] preRatio,
  input  logic               busWrEn,
  input  logic [CNT_W-1:0]   busWrData,
  input  logic               flagClr,
  output logic [CNT_W-1:0]   count,
  output logic               ovfFlag
);
  tmr_strobe_t strb;

  tick_timer_ctrl #(.PRE_W(PRE_W), .RATIO_W(RATIO_W), .SYNC_STAGES(2), .HOLD_TICKS(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .extPin(extPin), .srcSel(srcSel),
    .edgeSel(edgeSel), .preBypass(preBypass), .preRatio(preRatio), .busWrEn(busWrEn),
    .strb(strb)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData), .flagClr(flagClr),
    .count(count), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [CNT_W-1:0] busWrData,
  input logic             flagClr,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag
);
  p_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> count == $past(busWrData));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn ##1 !busWrEn |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busWrEn) && count != $past(count)) |-> count == CNT_W'($past(count) + 1'b1));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busWrEn) && (&$past(count)) && count == '0) |-> ovfFlag);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(flagClr)) |-> ovfFlag);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
  .flagClr(flagClr), .count(count), .ovfFlag(ovfFlag)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cycTick = 0, extPin = 0, srcSel = 0, edgeSel = 0, preBypass = 1;
  logic [2:0] preRatio = 0;
  logic busWrEn = 0, flagClr = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] count;
  logic ovfFlag;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R1";

  // reference model state
  logic mS1 = 0, mS2 = 0, mS3 = 0, mFlag = 0;
  logic [7:0] mPre = 0, mCnt = 0;
  int mHold = 0;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .cycTick(cycTick), .extPin(extPin), .srcSel(srcSel),
    .edgeSel(edgeSel), .preBypass(preBypass), .preRatio(preRatio), .busWrEn(busWrEn),
    .busWrData(busWrData), .flagClr(flagClr), .count(count), .ovfFlag(ovfFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic divHit(logic [7:0] pre, logic [2:0] ratio);
    int period = 2 << ratio;
    return ((int'(pre) + 1) % period) == 0;
  endfunction

  always @(posedge clk) begin
    logic edgeSeen, qual, inc, setF;
    cycles++;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mS3 = 0; mPre = 0; mCnt = 0; mHold = 0; mFlag = 0;
    end else begin
      edgeSeen = edgeSel ? (!mS2 && mS3) : (mS2 && !mS3);
      qual = srcSel ? edgeSeen : cycTick;
      inc = 0; setF = 0;
      if (busWrEn) begin
        mCnt = busWrData; mPre = 0; mHold = 2;
      end else begin
        if (qual && mHold == 0) begin
          if (preBypass) inc = 1;
          else begin
            inc = divHit(mPre, preRatio);
            mPre = mPre + 1;
          end
        end
        if (cycTick && mHold != 0) mHold = mHold - 1;
        if (inc) begin
          if (mCnt == 8'hFF) setF = 1;
          mCnt = mCnt + 1;
        end
      end
      if (setF) mFlag = 1;
      else if (flagClr) mFlag = 0;
      mS3 = mS2; mS2 = mS1; mS1 = extPin;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // drive at a falling edge, step one clock, compare with the model
  task automatic cyc(logic tk, logic pin, logic wr, logic [7:0] d, logic clr);
    cycTick = tk; extPin = pin; busWrEn = wr; busWrData = d; flagClr = clr;
    @(negedge clk);
    chk({curReq, " count"}, count, mCnt);
    chk({curReq, " flag"}, ovfFlag, mFlag);
  endtask

  initial begin
    logic [7:0] c0;
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("R1 count", count, 0);
    chk("R1 flag", ovfFlag, 0);
    rstN = 1;

    curReq = "R6";
    for (int i = 0; i < 8; i++) cyc(0, i[0], 0, 0, 0);
    chk("R6 pin in timer mode", count, 0);

    curReq = "R2";
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
    chk("R2 five ticks", count, 5);

    curReq = "R11";
    cyc(1, 0, 1, 8'hFE, 0);
    chk("R11 write wins", count, 8'hFE);

    curReq = "R8";
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    chk("R8 frozen", count, 8'hFE);

    curReq = "R9";
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    chk("R9 wrap count", count, 0);
    chk("R9 wrap flag", ovfFlag, 1);

    curReq = "R10";
    cyc(0, 0, 0, 0, 0);
    chk("R10 sticky", ovfFlag, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10 cleared", ovfFlag, 0);
    cyc(0, 0, 1, 8'hFF, 0); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1);
    chk("R10 set beats clear", ovfFlag, 1);

    curReq = "R3";
    preBypass = 0; preRatio = 3'd1;
    cyc(0, 0, 1, 8'h00, 1); cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    chk("R3 three of four", count, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R3 fourth tick", count, 1);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    chk("R3 eighth tick", count, 2);

    curReq = "R4";
    preBypass = 1; srcSel = 1; edgeSel = 0;
    c0 = count;
    cyc(1, 1, 0, 0, 0); cyc(1, 1, 0, 0, 0);
    chk("R4 not yet", count, c0);
    cyc(1, 1, 0, 0, 0);
    chk("R4 rising counted", count, c0 + 8'd1);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    chk("R4 falling ignored and R6 ticks ignored", count, c0 + 8'd1);

    curReq = "R5";
    edgeSel = 1;
    c0 = count;
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0);
    chk("R5 rising ignored", count, c0);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    chk("R5 falling counted", count, c0 + 8'd1);

    // constrained random phases against the model
    for (int p = 0; p < 40; p++) begin
      logic pin;
      pin = extPin;
      srcSel = p[0]; edgeSel = p[1]; preBypass = p[2];
      preRatio = 3'($urandom_range(0, 7));
      curReq = srcSel ? (edgeSel ? "R5" : "R4") : (preBypass ? "R2" : "R3");
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 3) == 0) pin = ~pin;
        cyc(1'($urandom_range(0, 1)), pin, $urandom_range(0, 60) == 0,
            8'($urandom_range(0, 255)), $urandom_range(0, 40) == 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule